// File: doc/BRIEF.md
# UART FIFO Control Register and Byte Queues

This block holds the FIFO control register of a UART together with the two byte queues it governs: one for transmit and one for receive, each 32 entries deep by default. The surrounding UART pushes received bytes into the receive queue and pops bytes to send from the transmit queue. The host side does the reverse. A receive threshold, picked by a 2-bit select, raises a flag once enough bytes are waiting.

A write to the control register carries three meaningful bits. Bit 0 turns queue mode on or off. Bit 1 clears the receive queue. Bit 2 clears the transmit queue. A write with bit 0 at 0 turns queue mode off and drops the clear bits. A clear bit that is accepted is held for one cycle and then drops by itself. In the cycle after that, the queue's pointers and level go back to zero. The stored bytes and anything outside this block are not touched.

A two-state mode machine governs the queues. `MD_HOLD` is the reset state: each direction acts as a one-byte holding register. `MD_QUEUE` gives each direction its full depth. The transition `T_ENABLE` (any write with bit 0 set, taken from `MD_HOLD`) moves to `MD_QUEUE`. The transition `T_DISABLE` (any write with bit 0 clear, taken from `MD_QUEUE`) returns to `MD_HOLD`. Any other write, and any cycle with no write, keeps the state.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset `fifo_en` is 0, both queues are empty with level 0, neither full flag is set, and `cfg_rdata` reads 3'b000.
- R2: A write with `cfg_wdata[0]`=1 sets `fifo_en` to 1 in the next cycle. A write with `cfg_wdata[0]`=0 sets it to 0 in the next cycle.
- R3: When `cfg_wdata[0]` is 0 in the same write, bits 1 and 2 of that write have no effect: neither level changes and `cfg_rdata[2:1]` stays 0.
- R4: A write with `cfg_wdata[0]`=1 and `cfg_wdata[1]`=1 makes `cfg_rdata[1]` read 1 in the following cycle. One cycle later the receive level is 0 and `cfg_rdata[1]` is back to 0. A receive push in that clearing cycle is dropped, and the transmit queue is unaffected.
- R5: A write with `cfg_wdata[0]`=1 and `cfg_wdata[2]`=1 clears the transmit queue with the same timing, using `cfg_rdata[2]`. A transmit push in the clearing cycle is dropped, and the receive queue is unaffected.
- R6: In queue mode each queue accepts DEPTH (32) bytes, raises full at DEPTH, and returns bytes in arrival order. The read data port always shows the oldest byte held.
- R7: A push into a full queue is dropped, even if a pop happens in the same cycle. A pop from an empty queue is ignored and the level stays 0.
- R8: In hold mode each queue takes one byte. Full is set whenever the level is 1 or more, and further pushes are dropped.
- R9: In queue mode `rx_trig_sel` codes 0, 1, 2 and 3 select thresholds of 1, 8, 16 and 28 bytes (1, DEPTH/4, DEPTH/2, DEPTH-4). In hold mode the threshold is 1. `rx_trig_hit` is 1 exactly when the receive level is at or above the threshold.
- R10: Level, empty, full and read data reflect a push or pop only after the clock edge that samples it. `rx_trig_hit` follows `rx_trig_sel` without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | Write data: bit 0 mode, bit 1 receive clear, bit 2 transmit clear |
| cfg_rdata | output | 3 | Register readback; bits 1 and 2 drop by themselves |
| fifo_en | output | 1 | 1 in queue mode, 0 in hold mode |
| tx_push | input | 1 | Host writes a byte to the transmit queue |
| tx_wdata | input | 8 | Byte to transmit |
| tx_pop | input | 1 | Serializer takes the oldest transmit byte |
| tx_rdata | output | 8 | Oldest transmit byte |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full for the current mode |
| tx_level | output | 6 | Bytes in the transmit queue |
| rx_push | input | 1 | Deserializer delivers a received byte |
| rx_wdata | input | 8 | Received byte |
| rx_pop | input | 1 | Host reads the oldest received byte |
| rx_rdata | output | 8 | Oldest received byte |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full for the current mode |
| rx_level | output | 6 | Bytes in the receive queue |
| rx_trig_sel | input | 2 | Receive threshold select |
| rx_trig_hit | output | 1 | Receive level at or above the threshold |

## Verification
The mode, levels, flags and read data of a push, pop or write are due one clock edge after the stimulus. A clear takes two edges: one to latch the clear bit and one to reset the pointers. `rx_trig_hit` follows the select within the same cycle. The bench drives inputs at the falling edge and samples at the next falling edge, so every register result is read exactly one edge later. Clear results are read after a second step. Threshold sweeps change the select and sample a moment later, between edges. One check samples the level just after a push is driven and before the next edge, to confirm nothing moves early.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    typedef enum logic {
        MD_HOLD  = 1'b0,
        MD_QUEUE = 1'b1
    } fifo_mode_e;

    function automatic int unsigned trig_bytes(input logic [1:0] sel, input int unsigned depth);
        unique case (sel)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - 4;
        endcase
    endfunction

endpackage

// File: rtl/uart_fifo_cfg.sv
module uart_fifo_cfg
    import uart_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [2:0] wdata,
    output logic       fifo_en,
    output logic       rx_clr,
    output logic       tx_clr
);

    fifo_mode_e state_q, state_d;
    logic       rx_clr_q, tx_clr_q;
    logic       accept;

    // Clear bits only count when the same write keeps bit 0 high.
    assign accept = we && wdata[0];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MD_HOLD:  if (accept)            state_d = MD_QUEUE; // T_ENABLE
            MD_QUEUE: if (we && !wdata[0])   state_d = MD_HOLD;  // T_DISABLE
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= MD_HOLD;
            rx_clr_q <= 1'b0;
            tx_clr_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            rx_clr_q <= accept && wdata[1];
            tx_clr_q <= accept && wdata[2];
        end
    end

    always_comb begin
        fifo_en = (state_q == MD_QUEUE);
        rx_clr  = rx_clr_q;
        tx_clr  = tx_clr_q;
    end

endmodule

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
    parameter  int W     = 8,
    parameter  int DEPTH = 32,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          one_deep,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          empty,
    output logic          full,
    output logic [LW-1:0] level
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] level_q, cap;
    logic          push_ok, pop_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign cap     = one_deep ? LW'(1) : LW'(DEPTH);
    assign empty   = (level_q == '0);
    assign full    = (level_q >= cap);
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign rdata   = mem[rd_ptr];
    assign level   = level_q;

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level_q <= '0;
        end else if (flush) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level_q <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            unique case ({push_ok, pop_ok})
                2'b10:   level_q <= level_q + LW'(1);
                2'b01:   level_q <= level_q - LW'(1);
                default: level_q <= level_q;
            endcase
        end
    end

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
    import uart_fifo_pkg::*;
#(
    parameter  int W     = 8,
    parameter  int DEPTH = 32,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_wdata,
    output logic [2:0]    cfg_rdata,
    output logic          fifo_en,
    input  logic          tx_push,
    input  logic [W-1:0]  tx_wdata,
    input  logic          tx_pop,
    output logic [W-1:0]  tx_rdata,
    output logic          tx_empty,
    output logic          tx_full,
    output logic [LW-1:0] tx_level,
    input  logic          rx_push,
    input  logic [W-1:0]  rx_wdata,
    input  logic          rx_pop,
    output logic [W-1:0]  rx_rdata,
    output logic          rx_empty,
    output logic          rx_full,
    output logic [LW-1:0] rx_level,
    input  logic [1:0]    rx_trig_sel,
    output logic          rx_trig_hit
);

    logic          en, rx_clr, tx_clr;
    logic [LW-1:0] trig_thr;

    uart_fifo_cfg i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .fifo_en (en),
        .rx_clr  (rx_clr),
        .tx_clr  (tx_clr)
    );

    uart_byte_fifo #(.W(W), .DEPTH(DEPTH)) i_tx_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (tx_clr),
        .one_deep (!en),
        .push     (tx_push),
        .wdata    (tx_wdata),
        .pop      (tx_pop),
        .rdata    (tx_rdata),
        .empty    (tx_empty),
        .full     (tx_full),
        .level    (tx_level)
    );

    uart_byte_fifo #(.W(W), .DEPTH(DEPTH)) i_rx_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (rx_clr),
        .one_deep (!en),
        .push     (rx_push),
        .wdata    (rx_wdata),
        .pop      (rx_pop),
        .rdata    (rx_rdata),
        .empty    (rx_empty),
        .full     (rx_full),
        .level    (rx_level)
    );

    assign trig_thr    = en ? LW'(trig_bytes(rx_trig_sel, DEPTH)) : LW'(1);
    assign rx_trig_hit = (rx_level >= trig_thr);
    assign fifo_en     = en;
    assign cfg_rdata   = {tx_clr, rx_clr, en};

endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk #(
    parameter int DEPTH = 32,
    parameter int LW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [2:0]    cfg_wdata,
    input logic [2:0]    cfg_rdata,
    input logic          fifo_en,
    input logic          tx_push,
    input logic          tx_pop,
    input logic          tx_full,
    input logic [LW-1:0] tx_level,
    input logic          rx_push,
    input logic          rx_pop,
    input logic          rx_empty,
    input logic          rx_full,
    input logic [LW-1:0] rx_level,
    input logic [1:0]    rx_trig_sel,
    input logic          rx_trig_hit
);

    AST_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_wdata[0] |=> fifo_en); // R2

    AST_NO_PROGRAM: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && !cfg_wdata[0] |=> !fifo_en && cfg_rdata[2:1] == 2'b00); // R3

    AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[1] |=> rx_level == '0); // R4

    AST_TX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[2] |=> tx_level == '0); // R5

    AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= LW'(DEPTH) && tx_level <= LW'(DEPTH)); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full && tx_push && !tx_pop |=> tx_level <= $past(tx_level)); // R7

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty && rx_pop && !rx_push |=> rx_level == '0); // R7

    AST_HOLD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en && !cfg_we && !cfg_rdata[1] && rx_empty && rx_push
        |=> rx_full && rx_level == LW'(1)); // R8

    AST_TRIG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_trig_hit) && $stable(rx_trig_sel) && $stable(fifo_en)
        |-> rx_level < $past(rx_level)); // R9

endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.DEPTH(DEPTH), .LW(LW)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .fifo_en     (fifo_en),
    .tx_push     (tx_push),
    .tx_pop      (tx_pop),
    .tx_full     (tx_full),
    .tx_level    (tx_level),
    .rx_push     (rx_push),
    .rx_pop      (rx_pop),
    .rx_empty    (rx_empty),
    .rx_full     (rx_full),
    .rx_level    (rx_level),
    .rx_trig_sel (rx_trig_sel),
    .rx_trig_hit (rx_trig_hit)
);

// File: tb/test_uart_fifo_ctl.sv
module test_uart_fifo_ctl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_wdata = '0;
    logic [2:0] cfg_rdata;
    logic       fifo_en;
    logic       tx_push = 1'b0, tx_pop = 1'b0;
    logic [7:0] tx_wdata = '0, tx_rdata;
    logic       tx_empty, tx_full;
    logic [5:0] tx_level;
    logic       rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] rx_wdata = '0, rx_rdata;
    logic       rx_empty, rx_full;
    logic [5:0] rx_level;
    logic [1:0] rx_trig_sel = '0;
    logic       rx_trig_hit;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    uart_fifo_ctl i_uart_fifo_ctl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .fifo_en(fifo_en),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
        .tx_empty(tx_empty), .tx_full(tx_full), .tx_level(tx_level),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .rx_empty(rx_empty), .rx_full(rx_full), .rx_level(rx_level),
        .rx_trig_sel(rx_trig_sel), .rx_trig_hit(rx_trig_hit)
    );

    typedef struct packed {
        logic       we;
        logic [2:0] wd;
        logic       txp, txo, rxp, rxo;
        logic [7:0] din;
        logic [1:0] ts;
        logic [5:0] etx, erx;
        logic       ehit, een;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0,3'd0,1'b0,1'b0,1'b1,1'b0,8'hA1,2'd0,6'd0,6'd1,1'b1,1'b0}, // R8 first byte held
        '{1'b0,3'd0,1'b0,1'b0,1'b1,1'b0,8'hA2,2'd0,6'd0,6'd1,1'b1,1'b0}, // R8 second dropped
        '{1'b0,3'd0,1'b1,1'b0,1'b0,1'b0,8'hB1,2'd0,6'd1,6'd1,1'b1,1'b0}, // R8 tx
        '{1'b0,3'd0,1'b1,1'b0,1'b0,1'b0,8'hB2,2'd0,6'd1,6'd1,1'b1,1'b0}, // R8 tx dropped
        '{1'b1,3'd1,1'b0,1'b0,1'b0,1'b0,8'h00,2'd0,6'd1,6'd1,1'b1,1'b1}, // R2 enable
        '{1'b0,3'd0,1'b0,1'b0,1'b1,1'b0,8'hA3,2'd1,6'd1,6'd2,1'b0,1'b1}, // R9 below 8
        '{1'b1,3'd6,1'b0,1'b0,1'b0,1'b0,8'h00,2'd1,6'd1,6'd2,1'b1,1'b0}, // R3 R2 disable
        '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,8'h00,2'd1,6'd1,6'd2,1'b1,1'b0}, // R3 no clear
        '{1'b0,3'd0,1'b0,1'b0,1'b1,1'b0,8'hA4,2'd1,6'd1,6'd2,1'b1,1'b0}, // R8 full drop
        '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b1,8'h00,2'd1,6'd1,6'd1,1'b1,1'b0}, // R9 hold thr 1
        '{1'b1,3'd3,1'b0,1'b0,1'b0,1'b0,8'h00,2'd1,6'd1,6'd1,1'b0,1'b1}, // R4 latch
        '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,8'h00,2'd1,6'd1,6'd0,1'b0,1'b1}, // R4 cleared
        '{1'b1,3'd5,1'b0,1'b0,1'b0,1'b0,8'h00,2'd1,6'd1,6'd0,1'b0,1'b1}, // R5 latch
        '{1'b0,3'd0,1'b1,1'b0,1'b0,1'b0,8'hB3,2'd1,6'd0,6'd0,1'b0,1'b1}, // R5 push dropped
        '{1'b0,3'd0,1'b1,1'b0,1'b0,1'b0,8'hB4,2'd1,6'd1,6'd0,1'b0,1'b1}  // R5 push after
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        cfg_we = 1'b0; tx_push = 1'b0; tx_pop = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int thr [4];
        thr[0] = 1; thr[1] = 8; thr[2] = 16; thr[3] = 28;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 fifo_en", fifo_en, 0);
        chk("R1 rx_level", rx_level, 0);
        chk("R1 tx_level", tx_level, 0);
        chk("R1 empties", {rx_empty, tx_empty}, 3);
        chk("R1 fulls", {rx_full, tx_full}, 0);
        chk("R1 cfg_rdata", cfg_rdata, 0);

        for (int v = 0; v < NV; v++) begin
            cfg_we = VECS[v].we;   cfg_wdata = VECS[v].wd;
            tx_push = VECS[v].txp; tx_pop = VECS[v].txo;
            rx_push = VECS[v].rxp; rx_pop = VECS[v].rxo;
            tx_wdata = VECS[v].din; rx_wdata = VECS[v].din;
            rx_trig_sel = VECS[v].ts;
            step();
            idle_inputs();
            chk($sformatf("vec%0d R2 R8 fifo_en", v), fifo_en, VECS[v].een);
            chk($sformatf("vec%0d R3 R8 tx_level", v), tx_level, VECS[v].etx);
            chk($sformatf("vec%0d R3 R8 rx_level", v), rx_level, VECS[v].erx);
            chk($sformatf("vec%0d R9 rx_trig_hit", v), rx_trig_hit, VECS[v].ehit);
            if (v == 0) chk("R8 held byte", rx_rdata, 8'hA1);
        end

        // R4 readback and self-clear; tx untouched
        cfg_we = 1'b1; cfg_wdata = 3'b011;
        step(); idle_inputs();
        chk("R4 rdata latched", cfg_rdata, 3);
        step();
        chk("R4 rdata self-clear", cfg_rdata, 1);
        chk("R4 tx untouched", tx_level, 1);

        // R5 readback and self-clear; rx untouched
        rx_push = 1'b1; rx_wdata = 8'h11;
        step(); idle_inputs();
        cfg_we = 1'b1; cfg_wdata = 3'b101;
        step(); idle_inputs();
        chk("R5 rdata latched", cfg_rdata, 5);
        step();
        chk("R5 rdata self-clear", cfg_rdata, 1);
        chk("R5 tx cleared", tx_level, 0);
        chk("R5 rx untouched", rx_level, 1);
        rx_pop = 1'b1;
        step(); idle_inputs();

        // R10 no early change
        rx_push = 1'b1; rx_wdata = 8'h40;
        #2 chk("R10 level before edge", rx_level, 0);
        step(); idle_inputs();
        chk("R10 level after edge", rx_level, 1);
        rx_pop = 1'b1;
        step(); idle_inputs();
        chk("R10 drained", rx_level, 0);

        // R6 fill, R9 threshold sweep at every level
        for (int i = 0; i < 32; i++) begin
            rx_push = 1'b1; rx_wdata = 8'h40 + 8'(i);
            step(); idle_inputs();
            chk("R6 fill level", rx_level, i + 1);
            for (int s = 0; s < 4; s++) begin
                rx_trig_sel = 2'(s);
                #1 chk($sformatf("R9 sel%0d lvl%0d", s, i + 1), rx_trig_hit, int'(i + 1 >= thr[s]));
            end
        end
        chk("R6 rx_full", rx_full, 1);
        chk("R6 oldest", rx_rdata, 8'h40);

        // R7 push into full with pop
        rx_push = 1'b1; rx_pop = 1'b1; rx_wdata = 8'hEE;
        step(); idle_inputs();
        chk("R7 full push dropped", rx_level, 31);
        for (int k = 1; k < 32; k++) begin
            chk("R6 order", rx_rdata, 8'h40 + k);
            rx_pop = 1'b1;
            step(); idle_inputs();
        end
        chk("R7 drained", rx_level, 0);
        rx_pop = 1'b1;
        step(); idle_inputs();
        chk("R7 empty pop level", rx_level, 0);
        chk("R7 empty flag", rx_empty, 1);
        rx_push = 1'b1; rx_wdata = 8'h77;
        step(); idle_inputs();
        chk("R6 wrap data", rx_rdata, 8'h77);
        chk("R6 wrap level", rx_level, 1);

        // R6 transmit depth
        for (int i = 0; i < 33; i++) begin
            tx_push = 1'b1; tx_wdata = 8'(i);
            step(); idle_inputs();
        end
        chk("R6 tx level cap", tx_level, 32);
        chk("R6 tx_full", tx_full, 1);
        chk("R6 tx oldest", tx_rdata, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule